// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command front end of a serial flash device for the path that updates its status register. While chip-select is low it shifts in bits from the serial data input on rising serial-clock edges. It recognises the two single-byte enable commands and the two-byte status-write command (opcode, then one data byte, MSB first). A status write lands only when chip-select returns high. At that moment it loads the block-protect field and the lock bit, subject to the live level of the hardware write-protect pin.

The serial pins are asynchronous to the core clock. They pass through a shared synchronizer, so their relative order is kept. A frame counts only if its bit count is exactly right: eight bits for an enable, sixteen for a status write. Any other frame, including one aborted partway through, leaves the protection fields alone and drops the enable. The current status byte is always visible on a parallel output. There is no data stream at the block's edge, so it has no valid/ready handshake.

Top module: `spi_sr_guard`

## Requirements
- R1: After reset the status output reads 8'h3C: lock bit (bit 7) clear, block-protect field (bits 5:2) all ones, enable flag (bit 1) clear.
- R2: A frame of exactly 8 bits carrying 8'h06 or 8'h50 sets the enable flag (status bit 1) once chip-select rises.
- R3: A frame of exactly 16 bits, opcode 8'h01 followed by a data byte sent MSB first, loads data bits 7 and 5:2 into status bits 7 and 5:2, provided the enable flag is set and the write is not locked out.
- R4: While chip-select is still low, the status output does not change, even after all 16 bits of a status write have been shifted in.
- R5: With write-protect low and the lock bit set, a status write changes no bit of bits 7 and 5:2.
- R6: With write-protect low and the lock bit clear, a status write is applied, and it may set the lock bit and change block-protect in the same frame.
- R7: With write-protect high, a status write may clear the lock bit as well as rewrite block-protect.
- R8: The write-protect level that decides R5 to R7 is the level present when chip-select rises, not the level during the bits.
- R9: A status write that arrives while the enable flag is clear has no effect.
- R10: Every completed frame that is not an enable frame clears the enable flag, including any status-write attempt and any frame carrying another opcode.
- R11: A frame with a bit count other than 8 or 16 (including zero and an aborted status write) changes no protection bit and clears the enable flag.
- R12: Frames behave the same whether the serial clock idles low (mode 0) or high (mode 3).
- R13: Status bits 6 and 0 always read 0, whatever data byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip-select, active low, frames a transaction |
| spi_sck | input | 1 | Serial clock, data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data into the device |
| spi_wp_n | input | 1 | Hardware write-protect, active low |
| status_o | output | 8 | Current status register value |

## Verification
On every cycle, the in-line assertions check four things. The status register moves only in the cycle after a chip-select rise. A locked register with write-protect low never changes its protection bits. A write without the enable flag is ignored. The enable flag follows the kind of frame that just closed. The bench's scenarios cover the rest: that the opcodes and data bits arrive in MSB-first order, that mode 0 and mode 3 framing match, that the protect level sampled at the chip-select rise is the one that decides, and that aborted frames have no effect. These scenarios are directed cases followed by seeded random frames, each compared against a reference model in the bench.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

  // Command codes
  localparam logic [7:0] OP_WRITE_EN  = 8'h06;
  localparam logic [7:0] OP_STATUS_EN = 8'h50;
  localparam logic [7:0] OP_STATUS_WR = 8'h01;

  // Status byte layout
  localparam int LOCK_POS  = 7;
  localparam int BP_HI_POS = 5;
  localparam int BP_LO_POS = 2;
  localparam int EN_POS    = 1;
  localparam int BP_W      = BP_HI_POS - BP_LO_POS + 1;

  // Frame lengths
  localparam int BYTE_BITS  = 8;
  localparam int WR_BITS    = 2 * BYTE_BITS;

  typedef struct packed {
    logic            lock;
    logic [BP_W-1:0] bp;
    logic            wen;
  } sr_state_t;

  function automatic logic [7:0] sr_pack(input sr_state_t s);
    logic [7:0] v;
    v = 8'h00;
    v[LOCK_POS]             = s.lock;
    v[BP_HI_POS:BP_LO_POS]  = s.bp;
    v[EN_POS]               = s.wen;
    return v;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          WIDTH     = 4,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= RST_VAL;
        end else if (g == 0) begin
          chain_q[g] <= d_i;
        end else begin
          chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int CNT_W   = 5,
  parameter int SHIFT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sck_s,
  input  logic               mosi_s,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               frame_end_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic               sck_prev_q;
  logic               cs_prev_q;
  logic               sck_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [SHIFT_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_n_s;
    end
  end

  assign sck_rise    = sck_s & ~sck_prev_q & ~cs_n_s;
  assign frame_end_o = cs_n_s & ~cs_prev_q;

  // Counter and shifter are cleared whenever chip-select is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_n_s) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (sck_rise) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      sh_q <= {sh_q[SHIFT_W-2:0], mosi_s};
    end
  end

  assign bit_cnt_o = cnt_q;
  assign shift_o   = sh_q;

  // R11: a frame that has closed leaves no residue for the next one
  p_frame_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (cnt_q == '0) && (sh_q == '0));

  // R4: the counter only advances on a serial clock rise inside a frame
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !sck_rise) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter int              CNT_W    = 5,
  parameter int              SHIFT_W  = 16,
  parameter logic [BP_W-1:0] BP_RESET = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               wp_n_s,
  output logic [7:0]         status_o
);

  sr_state_t  sr_q;
  logic [7:0] first_byte;
  logic [7:0] cmd_byte;
  logic [7:0] data_byte;
  logic       is_enable;
  logic       is_write;
  logic       write_ok;

  assign first_byte = shift_i[BYTE_BITS-1:0];
  assign cmd_byte   = shift_i[WR_BITS-1:BYTE_BITS];
  assign data_byte  = shift_i[BYTE_BITS-1:0];

  assign is_enable = (bit_cnt_i == CNT_W'(BYTE_BITS)) &&
                     ((first_byte == OP_WRITE_EN) || (first_byte == OP_STATUS_EN));
  assign is_write  = (bit_cnt_i == CNT_W'(WR_BITS)) && (cmd_byte == OP_STATUS_WR);
  assign write_ok  = sr_q.wen && (wp_n_s || !sr_q.lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q.lock <= 1'b0;
      sr_q.bp   <= BP_RESET;
      sr_q.wen  <= 1'b0;
    end else if (frame_end_i) begin
      sr_q.wen <= is_enable;
      if (is_write && write_ok) begin
        sr_q.lock <= data_byte[LOCK_POS];
        sr_q.bp   <= data_byte[BP_HI_POS:BP_LO_POS];
      end
    end
  end

  assign status_o = sr_pack(sr_q);

  // R4: the register only moves after a frame closes
  p_commit_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> $stable(status_o));

  // R5: locked with protect low keeps every protection bit
  p_lockdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_s && sr_q.lock) |=> $stable(status_o[7:2]));

  // R9: no enable, no write
  p_need_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !sr_q.wen) |=> $stable(status_o[7:2]));

  // R10: any frame other than an enable leaves the flag clear
  p_enable_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !is_enable) |=> !status_o[EN_POS]);

  // R2: an enable frame sets the flag
  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && is_enable) |=> status_o[EN_POS]);

endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              CNT_W       = 5,
  parameter logic [BP_W-1:0] BP_RESET    = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       spi_wp_n,
  output logic [7:0] status_o
);

  localparam int SHIFT_W = WR_BITS;
  localparam int PIN_N   = 4;
  // pin order: cs, sck, mosi, wp
  localparam logic [PIN_N-1:0] PIN_RST = 4'b1001;

  logic [PIN_N-1:0]   pins_s;
  logic [CNT_W-1:0]   bit_cnt;
  logic [SHIFT_W-1:0] shift_w;
  logic               frame_end;

  spi_pin_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({spi_cs_n, spi_sck, spi_mosi, spi_wp_n}),
    .q_o  (pins_s)
  );

  spi_frame_rx #(
    .CNT_W  (CNT_W),
    .SHIFT_W(SHIFT_W)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (pins_s[3]),
    .sck_s      (pins_s[2]),
    .mosi_s     (pins_s[1]),
    .bit_cnt_o  (bit_cnt),
    .shift_o    (shift_w),
    .frame_end_o(frame_end)
  );

  spi_sr_ctrl #(
    .CNT_W   (CNT_W),
    .SHIFT_W (SHIFT_W),
    .BP_RESET(BP_RESET)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end_i(frame_end),
    .bit_cnt_i  (bit_cnt),
    .shift_i    (shift_w),
    .wp_n_s     (pins_s[0]),
    .status_o   (status_o)
  );

endmodule

// File: tb/spi_sr_guard_bench.sv
module spi_sr_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       wp_n = 1'b1;
  logic [7:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic       m_lock;
  logic [3:0] m_bp;
  logic       m_wen;

  always #2 clk = ~clk;

  spi_sr_guard u_spi_sr_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_cs_n(cs_n),
    .spi_sck (sck),
    .spi_mosi(mosi),
    .spi_wp_n(wp_n),
    .status_o(status)
  );

  function automatic logic [7:0] model_status();
    return {m_lock, 1'b0, m_bp, m_wen, 1'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_frame(input logic [19:0] val, input int n, input logic wp_end);
    logic is_en, is_wr;
    is_en = (n == 8) && ((val[7:0] == 8'h06) || (val[7:0] == 8'h50));
    is_wr = (n == 16) && (val[15:8] == 8'h01);
    if (is_wr && m_wen && (wp_end || !m_lock)) begin
      m_lock = val[7];
      m_bp   = val[5:2];
    end
    m_wen = is_en;
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic frame_open(input bit mode3);
    sck = mode3;
    tick(4);
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic frame_bits(input logic [19:0] val, input int n, input bit mode3);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      sck  = 1'b0;
      tick(4);
      sck  = 1'b1;
      tick(4);
    end
    if (!mode3) sck = 1'b0;
    tick(4);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    tick(8);
  endtask

  // full frame: protect level held during the bits, then set to wp_end before chip-select rises
  task automatic run_frame(input logic [19:0] val, input int n, input bit mode3,
                           input logic wp_bits, input logic wp_end, input string req);
    wp_n = wp_bits;
    frame_open(mode3);
    frame_bits(val, n, mode3);
    wp_n = wp_end;
    tick(4);
    frame_close();
    model_frame(val, n, wp_end);
    check(req, status, model_status());
  endtask

  initial begin
    m_lock = 1'b0; m_bp = 4'hF; m_wen = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R1", status, 8'h3C);

    run_frame(20'h06, 8, 1'b0, 1'b1, 1'b1, "R2");
    check("R2", status, 8'h3E);

    // R4: mid-frame check after all 16 bits
    wp_n = 1'b1;
    frame_open(1'b0);
    frame_bits(20'h0100, 16, 1'b0);
    check("R4", status, 8'h3E);
    frame_close();
    model_frame(20'h0100, 16, 1'b1);
    check("R3", status, 8'h00);

    run_frame(20'h013C, 16, 1'b0, 1'b1, 1'b1, "R9");
    check("R9", status, 8'h00);

    run_frame(20'h50, 8, 1'b1, 1'b0, 1'b0, "R12");
    check("R12", status, 8'h02);
    run_frame(20'h01FF, 16, 1'b1, 1'b0, 1'b0, "R6");
    check("R13", status, 8'hBC);

    run_frame(20'h06, 8, 1'b0, 1'b0, 1'b0, "R2");
    run_frame(20'h0100, 16, 1'b0, 1'b0, 1'b0, "R5");
    check("R5", status, 8'hBC);

    run_frame(20'h06, 8, 1'b1, 1'b1, 1'b1, "R2");
    run_frame(20'h0100, 16, 1'b1, 1'b1, 1'b0, "R8");
    check("R8", status, 8'hBC);

    run_frame(20'h50, 8, 1'b0, 1'b0, 1'b0, "R2");
    run_frame(20'h0100, 16, 1'b0, 1'b0, 1'b1, "R7");
    check("R7", status, 8'h00);

    run_frame(20'h06, 8, 1'b0, 1'b1, 1'b1, "R2");
    run_frame(20'h01F, 12, 1'b0, 1'b1, 1'b1, "R11");
    check("R11", status, 8'h00);
    run_frame(20'h013C, 16, 1'b0, 1'b1, 1'b1, "R11");

    run_frame(20'h06, 8, 1'b0, 1'b1, 1'b1, "R2");
    run_frame(20'h05, 8, 1'b0, 1'b1, 1'b1, "R10");
    check("R10", status, 8'h00);

    run_frame(20'h50, 8, 1'b1, 1'b1, 1'b1, "R2");
    run_frame(20'h0, 0, 1'b1, 1'b1, 1'b1, "R11");
    check("R11", status, 8'h00);

    void'($urandom(32'd2024));
    for (int k = 0; k < 300; k++) begin
      logic [19:0] v;
      int          n;
      int          sel;
      sel = $urandom % 6;
      v   = 20'($urandom);
      case (sel)
        0: begin v = 20'h06; n = 8; end
        1: begin v = 20'h50; n = 8; end
        2: begin v = {4'h0, 8'h01, v[7:0]}; n = 16; end
        3: begin v = {4'h0, 8'h01, v[7:0]}; n = 8; end
        4: begin n = $urandom % 21; end
        default: begin v = {4'h0, 8'h01, v[7:0]}; n = (v[0]) ? 15 : 17; end
      endcase
      run_frame(v, n, 1'($urandom), 1'($urandom), 1'($urandom), "R3/R5-R12 random");
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run incomplete actual %0d cycles expected under 150000", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule